// File: doc/BRIEF.md
# Serial ADC conversion frame controller

This block is the host-side sequencer for a three-wire serial sampling converter. From the system clock it derives a free-running serial clock by an even divide ratio, issues a conversion strobe one serial-clock period wide, and shifts in the converter's reply from the serial data line. Each completed word appears on a parallel output with a one-cycle valid pulse.

The frame length sets the sample rate. It is a count of serial-clock rising edges between successive strobes, taken from an input when each frame is launched and forced up to the legal minimum of 17. A length of 18 gives the sample-and-hold an extra acquisition period. The result width is 12 or 14 bits, chosen per frame. A start pulse runs one frame. Holding the continuous input high runs frames back to back.

Top module: `adc_frame_ctrl`

## Requirements
- R1: `sclk_o` is a square wave whose high and low phases each last `CLK_HALF` system cycles, so a full serial period is 2*`CLK_HALF` cycles.
- R2: `conv_o` rises in the same system cycle that `sclk_o` falls, and it stays high for exactly one serial period (2*`CLK_HALF` system cycles, one rising edge of `sclk_o` inside).
- R3: In back-to-back frames, the number of `sclk_o` rising edges from one `conv_o` rise to the next equals `frame_len_i` as sampled at launch. Any value below 17 is treated as 17.
- R4: The bit present on `sdata_i` after the third `sclk_o` rising edge of a frame is the MSB. Each later rising edge brings the next lower bit. Every bit is sampled at the `sclk_o` falling edge that follows its rising edge.
- R5: `res14_i`=1 selects 14 data bits (rising edges 3..16) and `res14_i`=0 selects 12 (edges 3..14). The choice is latched at launch. The word is right-justified in `data_o` with unused upper bits zero, and `sdata_i` outside the data window has no effect on the result.
- R6: `valid_o` is high for exactly one system cycle, in the cycle right after the edge that samples the last data bit. `data_o` holds its value until the next valid pulse.
- R7: With `cont_i` low, each `start_i` pulse launches exactly one frame. A pulse that arrives during a frame is remembered and launches one further frame after the current one.
- R8: While `cont_i` is high, a new frame launches at the end of each frame. After `cont_i` falls, the running frame completes and no further strobe is issued.
- R9: During and right after reset, `sclk_o`, `conv_o` and `valid_o` are low and `data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-frame request pulse |
| cont_i | input | 1 | Continuous mode enable |
| res14_i | input | 1 | 1: 14-bit result, 0: 12-bit result |
| frame_len_i | input | FRAME_W | Serial-clock rising edges per frame (minimum 17 enforced) |
| sdata_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| conv_o | output | 1 | Conversion strobe |
| valid_o | output | 1 | One-cycle result-valid pulse |
| data_o | output | 14 | Right-justified captured word |

## Verification
A behavioural converter model drives known words MSB first from the third rising edge and holds the line high outside the data window. Alternating patterns, all-ones, single set bits at either end and the 12-bit versus 14-bit selection therefore show a shifted or misaligned window, a wrong sampling edge, and leakage of out-of-window bits into the upper field. Continuous bursts with lengths of 18, 17 and an illegal 10 separate correct edge counting from an off-by-one and from a missing clamp. Single-shot runs with an extra start pulse inside a frame, and idle stretches after one, show that queued requests are kept and that no stray frame is launched.

// File: rtl/adc_fc_pkg.sv
package adc_fc_pkg;
   localparam int unsigned MIN_FRAME       = 17;
   localparam int unsigned FIRST_DATA_EDGE = 3;
   localparam int unsigned RES_WIDE        = 14;
   localparam int unsigned RES_NARROW      = 12;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } fc_state_e;
endpackage

// File: rtl/fc_sclk_gen.sv
module fc_sclk_gen #(
   parameter int unsigned CLK_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic sclk_o,
   output logic rise_o,
   output logic fall_o
);
   logic sclk_q;

   generate
      if (CLK_HALF == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sclk_q <= 1'b0;
            else        sclk_q <= ~sclk_q;
         end
         assign rise_o = ~sclk_q;
         assign fall_o = sclk_q;
      end else begin : g_count
         localparam int unsigned CW = $clog2(CLK_HALF);
         logic [CW-1:0] cnt_q;
         logic          wrap;
         assign wrap = (cnt_q == CW'(CLK_HALF - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               sclk_q <= 1'b0;
            end else if (wrap) begin
               cnt_q  <= '0;
               sclk_q <= ~sclk_q;
            end else begin
               cnt_q  <= cnt_q + CW'(1);
            end
         end
         assign rise_o = wrap & ~sclk_q;
         assign fall_o = wrap & sclk_q;
      end
   endgenerate

   assign sclk_o = sclk_q;

   AST_RISE_TICK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> sclk_o); // R1
   AST_FALL_TICK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !sclk_o); // R1
endmodule

// File: rtl/fc_frame_seq.sv
module fc_frame_seq
   import adc_fc_pkg::*;
#(
   parameter int unsigned FRAME_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rise_i,
   input  logic               fall_i,
   input  logic               sclk_i,
   input  logic               start_i,
   input  logic               cont_i,
   input  logic               res14_i,
   input  logic [FRAME_W-1:0] frame_len_i,
   output logic               conv_o,
   output logic               launch_o,
   output logic               sample_o,
   output logic               last_o,
   output logic               w14_o
);
   localparam logic [FRAME_W-1:0] MIN_LEN   = FRAME_W'(MIN_FRAME);
   localparam logic [FRAME_W-1:0] FIRST_ED  = FRAME_W'(FIRST_DATA_EDGE);
   localparam logic [FRAME_W-1:0] LAST_WIDE = FRAME_W'(FIRST_DATA_EDGE + RES_WIDE - 1);
   localparam logic [FRAME_W-1:0] LAST_NARR = FRAME_W'(FIRST_DATA_EDGE + RES_NARROW - 1);

   fc_state_e          state_q;
   logic [FRAME_W-1:0] rcnt_q;
   logic [FRAME_W-1:0] len_q;
   logic [FRAME_W-1:0] len_in;
   logic [FRAME_W-1:0] last_edge;
   logic               pend_q;
   logic               conv_q;
   logic               w14_q;
   logic               want;
   logic               frame_end;
   logic               launch;

   assign len_in    = (frame_len_i < MIN_LEN) ? MIN_LEN : frame_len_i;
   assign last_edge = w14_q ? LAST_WIDE : LAST_NARR;
   assign want      = pend_q | start_i | cont_i;
   assign frame_end = (state_q == ST_RUN) && fall_i && (rcnt_q == len_q);
   assign launch    = fall_i && want && ((state_q == ST_IDLE) || (rcnt_q == len_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rcnt_q  <= '0;
         len_q   <= MIN_LEN;
         pend_q  <= 1'b0;
         conv_q  <= 1'b0;
         w14_q   <= 1'b1;
      end else begin
         if (launch)       pend_q <= 1'b0;
         else if (start_i) pend_q <= 1'b1;

         if (launch) begin
            state_q <= ST_RUN;
            rcnt_q  <= '0;
            len_q   <= len_in;
            w14_q   <= res14_i;
            conv_q  <= 1'b1;
         end else if (frame_end) begin
            state_q <= ST_IDLE;
            conv_q  <= 1'b0;
         end else if (state_q == ST_RUN) begin
            if (rise_i) rcnt_q <= rcnt_q + FRAME_W'(1);
            if (fall_i && (rcnt_q == FRAME_W'(1))) conv_q <= 1'b0;
         end
      end
   end

   assign sample_o = (state_q == ST_RUN) && fall_i &&
                     (rcnt_q >= FIRST_ED) && (rcnt_q <= last_edge);
   assign last_o   = sample_o && (rcnt_q == last_edge);
   assign launch_o = launch;
   assign conv_o   = conv_q;
   assign w14_o    = w14_q;

   AST_CONV_ON_SCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_q) |-> $fell(sclk_i)); // R2
   AST_CONV_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conv_q) |-> ($fell(sclk_i) && rcnt_q == FRAME_W'(1))); // R2
   AST_MIN_FRAME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_q) |-> ($past(state_q) == ST_IDLE || $past(rcnt_q) >= MIN_LEN)); // R3
   AST_NO_LAUNCH_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_q) |-> $past(pend_q | start_i | cont_i)); // R7
endmodule

// File: rtl/fc_rx_shift.sv
module fc_rx_shift
   import adc_fc_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_i,
   input  logic                sample_i,
   input  logic                last_i,
   input  logic                w14_i,
   input  logic                sdata_i,
   output logic                valid_o,
   output logic [RES_WIDE-1:0] data_o
);
   logic [RES_WIDE-1:0] shreg_q;
   logic [RES_WIDE-1:0] shnext;
   logic [RES_WIDE-1:0] data_q;
   logic                valid_q;

   assign shnext = {shreg_q[RES_WIDE-2:0], sdata_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         data_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= last_i;
         if (clear_i)       shreg_q <= '0;
         else if (sample_i) shreg_q <= shnext;
         if (last_i)        data_q  <= shnext;
      end
   end

   assign valid_o = valid_q;
   assign data_o  = data_q;

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q); // R6
   AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> $past(sample_i)); // R6
   AST_RIGHT_JUSTIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !w14_i) |-> (data_q[RES_WIDE-1:RES_NARROW] == '0)); // R5
   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q |-> $stable(data_q)); // R6
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
   import adc_fc_pkg::*;
#(
   parameter int unsigned CLK_HALF = 2,
   parameter int unsigned FRAME_W  = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                cont_i,
   input  logic                res14_i,
   input  logic [FRAME_W-1:0]  frame_len_i,
   input  logic                sdata_i,
   output logic                sclk_o,
   output logic                conv_o,
   output logic                valid_o,
   output logic [RES_WIDE-1:0] data_o
);
   generate
      if (CLK_HALF < 1) begin : g_bad_half
         $error("CLK_HALF must be at least 1");
      end
      if ((2 ** FRAME_W) <= MIN_FRAME) begin : g_bad_frame_w
         $error("FRAME_W too narrow to hold the minimum frame length");
      end
   endgenerate

   logic rise, fall, sclk;
   logic launch, sample, last, w14;

   fc_sclk_gen #(.CLK_HALF(CLK_HALF)) u_sclk (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_o (sclk),
      .rise_o (rise),
      .fall_o (fall)
   );

   fc_frame_seq #(.FRAME_W(FRAME_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .rise_i      (rise),
      .fall_i      (fall),
      .sclk_i      (sclk),
      .start_i     (start_i),
      .cont_i      (cont_i),
      .res14_i     (res14_i),
      .frame_len_i (frame_len_i),
      .conv_o      (conv_o),
      .launch_o    (launch),
      .sample_o    (sample),
      .last_o      (last),
      .w14_o       (w14)
   );

   fc_rx_shift u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (launch),
      .sample_i (sample),
      .last_i   (last),
      .w14_i    (w14),
      .sdata_i  (sdata_i),
      .valid_o  (valid_o),
      .data_o   (data_o)
   );

   assign sclk_o = sclk;
endmodule

// File: tb/adc_frame_ctrl_tb_top.sv
module adc_frame_ctrl_tb_top;
   localparam int HALF = 2;
   localparam int FW   = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, cont = 1'b0, res14 = 1'b1;
   logic [FW-1:0] flen = 6'd18;
   logic        sdata = 1'b1;
   logic        sclk, conv, valid;
   logic [13:0] data;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [13:0] send_q[$];
   logic [13:0] exp_q[$];
   int  conv_rises = 0, valid_cnt = 0;
   bit  gap_check = 0, gap_armed = 0;
   int  exp_gap = 0, gap_rises = 0;
   int  m_cnt = 0, m_w = 14, conv_hi = 0, sclk_per = 0;
   bit  sclk_seen = 0;
   logic [13:0] m_word = '0, last_exp = '0;
   logic prev_sclk = 1'b0, prev_conv = 1'b0, prev_valid = 1'b0;

   always #2.5 clk = ~clk;

   adc_frame_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cont_i(cont), .res14_i(res14),
      .frame_len_i(flen), .sdata_i(sdata), .sclk_o(sclk), .conv_o(conv),
      .valid_o(valid), .data_o(data)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // converter model and monitor, all on the falling system-clock edge
   always @(negedge clk) begin
      if (rst_n) begin
         sclk_per++;
         if (sclk && !prev_sclk) begin
            if (sclk_seen) chk(sclk_per == 2*HALF, "R1 sclk period", sclk_per, 2*HALF);
            sclk_seen = 1; sclk_per = 0;
            m_cnt++; gap_rises++;
            if (m_cnt >= 3 && m_cnt <= 2 + m_w) sdata = m_word[m_w - 1 - (m_cnt - 3)];
            else sdata = 1'b1;
         end
         if (conv) conv_hi++;
         if (conv && !prev_conv) begin
            chk(!sclk && prev_sclk, "R2 strobe on sclk fall", sclk, 0);
            if (gap_check && gap_armed) chk(gap_rises == exp_gap, "R3 frame gap", gap_rises, exp_gap);
            gap_armed = gap_check; gap_rises = 0;
            conv_rises++; m_cnt = 0; conv_hi = 1;
            m_w = res14 ? 14 : 12;
            m_word = (send_q.size() > 0) ? send_q.pop_front() : 14'h0;
         end
         if (!conv && prev_conv) chk(conv_hi == 2*HALF, "R2 strobe width", conv_hi, 2*HALF);
         if (valid) begin
            valid_cnt++;
            chk(!prev_valid, "R6 single-cycle valid", 1, 0);
            chk(!sclk && m_cnt == 2 + m_w, "R6 valid timing", m_cnt, 2 + m_w);
            if (exp_q.size() == 0) chk(0, "R4 unexpected result", data, 0);
            else begin
               last_exp = exp_q.pop_front();
               chk(data == last_exp, m_w == 14 ? "R4 14-bit word" : "R5 12-bit word", data, last_exp);
            end
         end
         prev_sclk = sclk; prev_conv = conv; prev_valid = valid;
      end
   end

   task automatic push(input logic [13:0] w, input bit wide);
      send_q.push_back(w);
      exp_q.push_back(wide ? w : (w & 14'h0FFF));
   endtask

   task automatic single(input logic [13:0] w, input bit wide, input int len);
      int v0;
      @(negedge clk);
      res14 = wide; flen = FW'(len); push(w, wide);
      v0 = valid_cnt;
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait (valid_cnt == v0 + 1);
      repeat (40 * HALF) @(negedge clk);
   endtask

   task automatic burst(input int n, input bit wide, input int len);
      int v0;
      @(negedge clk);
      res14 = wide; flen = FW'(len);
      exp_gap = (len < 17) ? 17 : len;
      for (int i = 0; i < n; i++) push(14'((i * 14'h1357) ^ 14'h2C3A), wide);
      v0 = valid_cnt; gap_check = 1; gap_armed = 0;
      cont = 1'b1;
      wait (valid_cnt == v0 + n);
      cont = 1'b0;
      repeat (60 * HALF) @(negedge clk);
      gap_check = 0;
   endtask

   initial begin
      int c0;
      // R9 reset state
      repeat (3) @(negedge clk);
      chk(sclk == 0 && conv == 0 && valid == 0, "R9 reset outputs", {sclk, conv, valid}, 0);
      chk(data == 0, "R9 reset data", data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(conv == 0 && valid == 0 && data == 0, "R9 after release", {conv, valid}, 0);

      // R4 / R5 single frames with distinct patterns
      single(14'h2AAA, 1, 18);
      single(14'h3FFF, 1, 17);
      single(14'h0001, 1, 20);
      single(14'h2000, 1, 18);
      single(14'h0A5A, 0, 18);
      single(14'h3FFF, 0, 17);
      single(14'h0800, 0, 19);

      // R7 no stray frame after a single shot
      c0 = conv_rises;
      repeat (200) @(negedge clk);
      chk(conv_rises == c0, "R7 idle stays idle", conv_rises - c0, 0);
      chk(data == last_exp, "R6 data held", data, last_exp);

      // R7 start during a frame is queued for exactly one more frame
      c0 = conv_rises;
      res14 = 1; flen = 6'd18;
      push(14'h1234, 1); push(14'h0F0F, 1);
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (10) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (200) @(negedge clk);
      chk(conv_rises - c0 == 2, "R7 queued start", conv_rises - c0, 2);

      // R3 / R8 continuous bursts
      c0 = conv_rises;
      burst(4, 1, 18);
      chk(conv_rises - c0 == 4, "R8 burst stops", conv_rises - c0, 4);
      c0 = conv_rises;
      burst(3, 0, 17);
      chk(conv_rises - c0 == 3, "R8 burst of 17", conv_rises - c0, 3);
      c0 = conv_rises;
      burst(3, 1, 10);
      chk(conv_rises - c0 == 3, "R3 clamped burst", conv_rises - c0, 3);

      chk(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule